// File: doc/BRIEF.md
# Memory-Card Slot Status and Insertion Interrupt Registers

This block is a small word-indexed register window on a baseboard. It watches a memory-card slot and raises an interrupt when a card goes in. A card controller drives two lines into it. The write-protect line is a plain level. The card-present line is an event that the block captures and holds.

Software reads four words through the window:
- a fixed identity word;
- a flash-programming word that always reads zero;
- a slot status word;
- a fixed address-decode word.

In the status word, the write-protect level is live and simply follows the input. The card-present bit is sticky. It stays set until software writes a one to its position. The interrupt output is a direct image of that sticky bit.

Both slot lines are asynchronous to the bus clock, so each one passes through a synchronizer before any logic uses it. Read data is registered: a read presented in one cycle returns its word on the following cycle, and that word is held until the next read. An access to an index outside the four defined words reads as zero and gives a one-cycle error pulse.

Top module: `slot_status_regs`

## Requirements
- R1: After reset, the outputs are cleared: `irq` is 0, `rdata` is 0 and `err` is 0. A read of status index 2 with both slot lines low returns 0.
- R2: A read of index 0 returns 0x41034003. A read of index 1 returns 0. A read of index 3 returns 0x11. None of these reads raises `err`.
- R3: Writes to indices 0, 1 and 3 change nothing. Those words read back unchanged, `irq` keeps its value, and `err` stays low.
- R4: Status bit 0 equals `wp_in` after a two-stage synchronizer. After `wp_in` changes just before a clock edge, the first two reads still return the old level, and the third read returns the new level.
- R5: Status bit 3 is set once the synchronized `card_in` is high. With the default depth, it is set on the third rising edge after `card_in` rises. It stays set after `card_in` falls.
- R6: A write to index 2 clears bit 3 only when bit 3 of `wdata` is 1. A write with `wdata` bit 3 equal to 0 leaves bit 3 unchanged. No write alters bit 0. All other status bits always read 0.
- R7: `irq` is high exactly while status bit 3 is set. After a clearing write, `irq` is low from the next clock edge.
- R8: If the synchronized `card_in` is high in the same cycle as a clearing write, the set wins and bit 3 stays 1.
- R9: An access to any index of 4 or above has these effects:
  - a read returns 0;
  - a write changes no state;
  - `err` is high for the one cycle after the access.
- R10: `rdata` is updated only on the edge that samples `rd_en`. It holds its value through idle cycles, even if the status changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (4) | Word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| err | output | 1 | One-cycle pulse after an access to an unknown index |
| wp_in | input | 1 | Write-protect level from the card controller (asynchronous) |
| card_in | input | 1 | Card-inserted indication from the card controller (asynchronous) |
| irq | output | 1 | Card-insertion interrupt, high while the sticky bit is set |

## Verification
Two things can land on the sticky card bit in the same cycle: the set from the synchronized card line and the clear from a software write. The bench provokes this by holding `card_in` high until the synchronizer output is high, then issuing the clearing write. It judges the result by checking that `irq` stays high and that a status read still shows bit 3. After that, it drops `card_in`, lets the synchronizer drain, and repeats the write to confirm that the clear on its own does take effect.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;

   // Word indices inside the window
   localparam int unsigned IDX_IDENT  = 0;
   localparam int unsigned IDX_FLASH  = 1;
   localparam int unsigned IDX_STATUS = 2;
   localparam int unsigned IDX_DECODE = 3;
   localparam int unsigned NUM_WORDS  = 4;
   localparam int unsigned SEL_W      = $clog2(NUM_WORDS);

   typedef enum logic [SEL_W-1:0] {
      SEL_IDENT  = 2'd0,
      SEL_FLASH  = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_DECODE = 2'd3
   } word_sel_e;

   // Slot line positions inside the synchronizer vector
   localparam int unsigned LINE_WP   = 0;
   localparam int unsigned LINE_CARD = 1;
   localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slot_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("slot_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= stage_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/slot_card_latch.sv
module slot_card_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;
   logic flag_d;

   // Set has priority over a software clear in the same cycle
   always_comb begin
      flag_d = flag_q;
      if (set_i)      flag_d = 1'b1;
      else if (clr_i) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);                               // R8
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);                  // R6
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);                  // R5
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);                // R5

endmodule

// File: rtl/slot_reg_decode.sv
module slot_reg_decode
   import slot_regs_pkg::*;
#(
   parameter int unsigned        DATA_W     = 32,
   parameter int unsigned        ADDR_W     = 4,
   parameter int unsigned        WP_BIT     = 0,
   parameter int unsigned        CARD_BIT   = 3,
   parameter logic [DATA_W-1:0]  IDENT_VAL  = 32'h4103_4003,
   parameter logic [DATA_W-1:0]  FLASH_VAL  = '0,
   parameter logic [DATA_W-1:0]  DECODE_VAL = 32'h0000_0011,
   parameter bit                 REG_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wp_level,
   input  logic              card_flag,
   output logic              clr_req,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   logic              known;
   word_sel_e         sel;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] rd_word;
   logic              err_q;

   // Index range check: only indices below NUM_WORDS are defined
   generate
      if (ADDR_W == SEL_W) begin : g_full_window
         assign known = 1'b1;
      end else begin : g_wide_window
         assign known = ~|addr[ADDR_W-1:SEL_W];
      end
   endgenerate

   assign sel = word_sel_e'(addr[SEL_W-1:0]);

   always_comb begin
      status_word           = '0;
      status_word[WP_BIT]   = wp_level;
      status_word[CARD_BIT] = card_flag;
   end

   always_comb begin
      rd_word = '0;
      if (known) begin
         unique case (sel)
            SEL_IDENT:  rd_word = IDENT_VAL;
            SEL_FLASH:  rd_word = FLASH_VAL;
            SEL_STATUS: rd_word = status_word;
            SEL_DECODE: rd_word = DECODE_VAL;
            default:    rd_word = '0;
         endcase
      end
   end

   // Only the status word responds to writes, and only its card bit
   assign clr_req = wr_en && known && (sel == SEL_STATUS) && wdata[CARD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (rd_en || wr_en) && !known;
   end
   assign err = err_q;

   generate
      if (REG_RDATA) begin : g_reg_read
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_word;
         end
         assign rdata = rdata_q;

         AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !known) |=> (rdata == '0));                 // R9
         AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && known && sel == SEL_IDENT) |=> (rdata == IDENT_VAL)); // R2
         AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rdata));                           // R10
      end else begin : g_comb_read
         assign rdata = rd_en ? rd_word : '0;
      end
   endgenerate

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past((rd_en || wr_en) && |(addr >> SEL_W)));  // R9

endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
   import slot_regs_pkg::*;
#(
   parameter int unsigned        DATA_W      = 32,
   parameter int unsigned        ADDR_W      = 4,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter int unsigned        WP_BIT      = 0,
   parameter int unsigned        CARD_BIT    = 3,
   parameter logic [DATA_W-1:0]  IDENT_VAL   = 32'h4103_4003,
   parameter logic [DATA_W-1:0]  FLASH_VAL   = '0,
   parameter logic [DATA_W-1:0]  DECODE_VAL  = 32'h0000_0011,
   parameter bit                 REG_RDATA   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   input  logic              wp_in,
   input  logic              card_in,
   output logic              irq
);

   generate
      if (ADDR_W < SEL_W) begin : g_bad_addr
         $error("slot_status_regs: ADDR_W too small for four words");
      end
      if (CARD_BIT >= DATA_W || WP_BIT >= DATA_W) begin : g_bad_bits
         $error("slot_status_regs: status bit position outside data word");
      end
      if (CARD_BIT == WP_BIT) begin : g_bit_clash
         $error("slot_status_regs: card and write-protect bits overlap");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("slot_status_regs: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_LINES-1:0] lines_async;
   logic [NUM_LINES-1:0] lines_sync;
   logic                 card_flag;
   logic                 clr_req;

   always_comb begin
      lines_async            = '0;
      lines_async[LINE_WP]   = wp_in;
      lines_async[LINE_CARD] = card_in;
   end

   slot_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (NUM_LINES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (lines_async),
      .sync_o  (lines_sync)
   );

   slot_card_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (lines_sync[LINE_CARD]),
      .clr_i  (clr_req),
      .flag_o (card_flag)
   );

   slot_reg_decode #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .WP_BIT     (WP_BIT),
      .CARD_BIT   (CARD_BIT),
      .IDENT_VAL  (IDENT_VAL),
      .FLASH_VAL  (FLASH_VAL),
      .DECODE_VAL (DECODE_VAL),
      .REG_RDATA  (REG_RDATA)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .wp_level  (lines_sync[LINE_WP]),
      .card_flag (card_flag),
      .clr_req   (clr_req),
      .rdata     (rdata),
      .err       (err)
   );

   assign irq = card_flag;

   generate
      if (REG_RDATA) begin : g_irq_checks
         AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(IDX_STATUS)) |=> (rdata[CARD_BIT] == $past(irq))); // R7
         AST_WP_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(IDX_STATUS)) |=> (rdata[WP_BIT] == $past(lines_sync[LINE_WP]))); // R4
      end
   endgenerate

   AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(IDX_STATUS) && wdata[CARD_BIT] && !lines_sync[LINE_CARD]) |=> !irq); // R7

endmodule

// File: tb/slot_status_regs_bench.sv
module slot_status_regs_bench;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam logic [DW-1:0] ID_WORD  = 32'h4103_4003;
   localparam logic [DW-1:0] DEC_WORD = 32'h0000_0011;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          err;
   logic          wp_in = 1'b0;
   logic          card_in = 1'b0;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   slot_status_regs u_slot_status_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .err     (err),
      .wp_in   (wp_in),
      .card_in (card_in),
      .irq     (irq)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge
   task automatic do_read(input logic [AW-1:0] idx, output logic [DW-1:0] data, output logic e);
      addr  = idx;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      data  = rdata;
      e     = err;
   endtask

   task automatic do_write(input logic [AW-1:0] idx, input logic [DW-1:0] val, output logic e);
      addr  = idx;
      wdata = val;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      wdata = '0;
      e     = err;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d; logic e;
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 rdata", rdata, 32'd0);
      check("R1 err", {31'd0, err}, 32'd0);
      do_read(4'd2, d, e);
      check("R1 status", d, 32'd0);
   endtask

   task automatic t_constants();
      logic [DW-1:0] d; logic e;
      do_read(4'd0, d, e); check("R2 ident", d, ID_WORD);   check("R2 ident err", {31'd0, e}, 32'd0);
      do_read(4'd1, d, e); check("R2 flash", d, 32'd0);     check("R2 flash err", {31'd0, e}, 32'd0);
      do_read(4'd3, d, e); check("R2 decode", d, DEC_WORD); check("R2 decode err", {31'd0, e}, 32'd0);
   endtask

   task automatic t_ignored_writes();
      logic [DW-1:0] d; logic e;
      do_write(4'd0, 32'hFFFF_FFFF, e); check("R3 wr0 err", {31'd0, e}, 32'd0);
      do_write(4'd1, 32'hFFFF_FFFF, e); check("R3 wr1 err", {31'd0, e}, 32'd0);
      do_write(4'd3, 32'hFFFF_FFFF, e); check("R3 wr3 err", {31'd0, e}, 32'd0);
      do_read(4'd0, d, e); check("R3 ident after write", d, ID_WORD);
      do_read(4'd1, d, e); check("R3 flash after write", d, 32'd0);
      do_read(4'd3, d, e); check("R3 decode after write", d, DEC_WORD);
      do_read(4'd2, d, e); check("R3 status after write", d, 32'd0);
      check("R3 irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_wp_level();
      logic [DW-1:0] d; logic e;
      wp_in = 1'b1;
      do_read(4'd2, d, e); check("R4 rise read1", d, 32'd0);
      do_read(4'd2, d, e); check("R4 rise read2", d, 32'd0);
      do_read(4'd2, d, e); check("R4 rise read3", d, 32'd1);
      check("R4 irq untouched", {31'd0, irq}, 32'd0);
      wp_in = 1'b0;
      do_read(4'd2, d, e); check("R4 fall read1", d, 32'd1);
      do_read(4'd2, d, e); check("R4 fall read2", d, 32'd1);
      do_read(4'd2, d, e); check("R4 fall read3", d, 32'd0);
   endtask

   task automatic t_card_sticky();
      logic [DW-1:0] d; logic e;
      card_in = 1'b1;
      idle(2);
      check("R5 not yet set", {31'd0, irq}, 32'd0);
      idle(1);
      check("R5 set on third edge", {31'd0, irq}, 32'd1);
      card_in = 1'b0;
      idle(6);
      check("R5 sticky irq", {31'd0, irq}, 32'd1);
      do_read(4'd2, d, e); check("R5 sticky status", d, 32'h8);
   endtask

   task automatic t_clear();
      logic [DW-1:0] d; logic e;
      wp_in = 1'b1;
      idle(3);
      do_write(4'd2, 32'hFFFF_FFF7, e);
      check("R6 no-bit3 write keeps irq", {31'd0, irq}, 32'd1);
      do_read(4'd2, d, e); check("R6 no-bit3 write keeps status", d, 32'h9);
      do_write(4'd2, 32'h0000_0008, e);
      check("R7 irq drops after clear", {31'd0, irq}, 32'd0);
      do_read(4'd2, d, e); check("R6 clear leaves wp bit", d, 32'h1);
      wp_in = 1'b0;
      idle(3);
   endtask

   task automatic t_priority();
      logic [DW-1:0] d; logic e;
      card_in = 1'b1;
      idle(4);
      check("R8 latched", {31'd0, irq}, 32'd1);
      do_write(4'd2, 32'hFFFF_FFFF, e);
      check("R8 set wins irq", {31'd0, irq}, 32'd1);
      do_read(4'd2, d, e); check("R8 set wins status", d, 32'h8);
      card_in = 1'b0;
      idle(3);
      do_write(4'd2, 32'h0000_0008, e);
      check("R8 clear after release", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_unknown();
      logic [DW-1:0] d; logic e;
      do_read(4'd4, d, e);  check("R9 idx4 data", d, 32'd0);  check("R9 idx4 err", {31'd0, e}, 32'd1);
      do_read(4'd15, d, e); check("R9 idx15 data", d, 32'd0); check("R9 idx15 err", {31'd0, e}, 32'd1);
      do_read(4'd6, d, e);  check("R9 idx6 data", d, 32'd0);  check("R9 idx6 err", {31'd0, e}, 32'd1);
      do_write(4'd10, 32'hFFFF_FFFF, e); check("R9 write err", {31'd0, e}, 32'd1);
      idle(1);
      check("R9 err one cycle", {31'd0, err}, 32'd0);
      do_read(4'd2, d, e); check("R9 state untouched", d, 32'd0); check("R9 valid no err", {31'd0, e}, 32'd0);
   endtask

   task automatic t_hold();
      logic [DW-1:0] d; logic e;
      do_read(4'd0, d, e);
      card_in = 1'b1;
      idle(5);
      check("R10 rdata held", rdata, ID_WORD);
      card_in = 1'b0;
      do_read(4'd2, d, e); check("R10 new read updates", d, 32'h8);
      do_write(4'd2, 32'h8, e);
      idle(2);
      check("R10 held over write", rdata, 32'h8);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_constants();
      t_ignored_writes();
      t_wp_level();
      t_card_sticky();
      t_clear();
      t_priority();
      t_unknown();
      t_hold();
      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule